// File: doc/BRIEF.md
# Device error signaling decision unit

This unit receives one detected error per request and turns it into register update strobes, an optional log-record request and an optional outgoing error message. Each request carries an error status vector, a flag that selects the correctable or uncorrectable class, and a flag that marks a non-fatal error as a candidate for advisory handling. The unit reads the correctable and uncorrectable mask registers, the uncorrectable severity register, the per-class reporting enables and the command system-error enable.

The checks run in a fixed order. First the status is qualified. Then device status is updated and the error status is set. Next come the mask test, the logging decision, the unsupported-request suppression and finally the per-class enable gating. Every result is registered, so all outputs appear as one-cycle pulses in the cycle after the request. The status registers, the header log and the upstream forwarding of messages sit in neighbouring blocks that act on these pulses.

Top module: `errsig_unit`

## Requirements
- R1: After reset, and in any cycle that does not follow a request, every output is low or zero.
- R2: The request status is ANDed with the supported bits of its class (correctable `COR_SUPPORTED`, uncorrectable `UNC_SUPPORTED`). A zero result, or one with more than one bit set, raises only `req_reject` and no other output.
- R3: A correctable request sets `sta_cor_det` and sets its own bit in `cor_status_set`. If that bit is set in `cor_mask`, no message is sent.
- R4: A correctable message needs `en_cor_report`. It carries severity code 2'b01.
- R5: An uncorrectable error is fatal when its bit is set in `unc_severity`; it then sets `sta_fatal_det`, and otherwise it sets `sta_nonfatal_det`. The unsupported-request error (bit `UR_BIT`, default 20) also sets `sta_ur_det`.
- R6: A masked uncorrectable error sets its bit in `unc_status_set`. It raises neither `log_valid` nor `msg_valid`.
- R7: An unmasked uncorrectable error raises `log_valid` with `log_status` equal to its bit, and sets the same bit in `unc_status_set`.
- R8: A fatal message (code 2'b11) or a non-fatal message (code 2'b10) is sent when `sys_err_en` is set or when the matching class enable is set.
- R9: An unsupported request is never reported when both `en_ur_report` and `sys_err_en` are clear. On the advisory path only `en_ur_report` can release it.
- R10: A non-fatal request with `req_advisory` set is handled as a correctable error on bit `ADV_BIT` (default 13). The mask test uses that correctable bit. If the error passes that test, it is logged and its uncorrectable status bit is set, but only when the bit is clear in `unc_mask`. Any message it produces is correctable. A fatal request ignores `req_advisory`.
- R11: A message appears as a single-cycle `msg_valid` pulse with a non-zero severity, exactly one cycle after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Error request present this cycle |
| req_status | input | 32 | Error status vector, exactly one supported bit expected |
| req_correctable | input | 1 | 1 selects the correctable class |
| req_advisory | input | 1 | Non-fatal error may be handled as advisory |
| unc_mask | input | 32 | Uncorrectable mask register |
| unc_severity | input | 32 | Uncorrectable severity register (1 = fatal) |
| cor_mask | input | 32 | Correctable mask register |
| en_cor_report | input | 1 | Correctable reporting enable |
| en_nonfatal_report | input | 1 | Non-fatal reporting enable |
| en_fatal_report | input | 1 | Fatal reporting enable |
| en_ur_report | input | 1 | Unsupported-request reporting enable |
| sys_err_en | input | 1 | Command system-error enable |
| req_reject | output | 1 | Request status was malformed |
| sta_cor_det | output | 1 | Set correctable-detected in device status |
| sta_nonfatal_det | output | 1 | Set non-fatal-detected in device status |
| sta_fatal_det | output | 1 | Set fatal-detected in device status |
| sta_ur_det | output | 1 | Set unsupported-request-detected in device status |
| cor_status_set | output | 32 | Bits to set in correctable status |
| unc_status_set | output | 32 | Bits to set in uncorrectable status |
| log_valid | output | 1 | Record the error in the header log |
| log_status | output | 32 | Error bit to record |
| msg_valid | output | 1 | Error message goes out |
| msg_severity | output | 2 | 01 correctable, 10 non-fatal, 11 fatal |

## Verification
The only state in the unit is a single output register. A wrong decision, such as an inverted mask test, a swapped severity or a missing enable term, therefore shows at the ports in the cycle right after the offending request, and nothing carries over to later requests. The stimulus focuses on the places where the checking order matters: the advisory conversion, where the correctable mask is tested before the uncorrectable one, and an unsupported request that the system-error enable can release on the uncorrectable path but not on the advisory path. A stuck output register would show either as a pulse that lasts into an idle cycle or as a reject that also carries strobes.

// File: rtl/errsig_pkg.sv
package errsig_pkg;

    parameter int unsigned ERR_W = 32;

    typedef logic [ERR_W-1:0] errvec_t;

    typedef enum logic [1:0] {
        SEV_NONE     = 2'b00,
        SEV_COR      = 2'b01,
        SEV_NONFATAL = 2'b10,
        SEV_FATAL    = 2'b11
    } sev_e;

    // Qualified request, produced by err_qualify
    typedef struct packed {
        logic    ok;
        logic    bad;
        logic    corr;
        logic    adv;
        logic    ur;
        logic    fatal;
        errvec_t bits;
    } qual_t;

    // Per-request outcome, registered at the top
    typedef struct packed {
        logic    reject;
        logic    cor_det;
        logic    nonfatal_det;
        logic    fatal_det;
        logic    ur_det;
        errvec_t cor_set;
        errvec_t unc_set;
        logic    log_req;
        errvec_t log_bits;
        logic    msg;
        sev_e    sev;
    } verdict_t;

    function automatic logic exactly_one(errvec_t v);
        return (v != '0) && ((v & (v - errvec_t'(1))) == '0);
    endfunction

endpackage

// File: rtl/err_qualify.sv
module err_qualify
    import errsig_pkg::*;
#(
    parameter errvec_t     COR_SUPPORTED = 32'h0000_F1C1,
    parameter errvec_t     UNC_SUPPORTED = 32'h03FF_F030,
    parameter int unsigned UR_BIT        = 20
) (
    input  logic    valid,
    input  errvec_t status,
    input  logic    correctable,
    input  logic    advisory,
    input  errvec_t severity,
    output qual_t   q
);
    errvec_t bits;
    logic    single;
    logic    fatal;

    always_comb begin
        bits   = status & (correctable ? COR_SUPPORTED : UNC_SUPPORTED);
        single = exactly_one(bits);
        fatal  = !correctable && ((bits & severity) != '0);
        q.ok    = valid && single;
        q.bad   = valid && !single;
        q.corr  = correctable;
        q.fatal = fatal;
        q.ur    = !correctable && bits[UR_BIT];
        q.adv   = advisory && !correctable && !fatal;
        q.bits  = bits;
    end
endmodule

// File: rtl/err_decide.sv
module err_decide
    import errsig_pkg::*;
#(
    parameter int unsigned ADV_BIT = 13
) (
    input  qual_t    q,
    input  errvec_t  unc_mask,
    input  errvec_t  cor_mask,
    input  logic     en_cor,
    input  logic     en_nonfatal,
    input  logic     en_fatal,
    input  logic     en_ur,
    input  logic     serr,
    output verdict_t v
);
    localparam errvec_t ADV_ONEHOT = errvec_t'(1) << ADV_BIT;

    errvec_t cor_bit;
    logic    unc_open;
    logic    class_en;

    always_comb begin
        v        = '0;
        v.sev    = SEV_NONE;
        cor_bit  = q.corr ? q.bits : ADV_ONEHOT;
        unc_open = (unc_mask & q.bits) == '0;
        class_en = serr || (q.fatal ? en_fatal : en_nonfatal);
        if (q.bad) begin
            v.reject = 1'b1;
        end else if (q.ok) begin
            if (q.corr || q.adv) begin
                // correctable path, including the advisory conversion
                v.cor_det = 1'b1;
                v.ur_det  = q.ur;
                v.cor_set = cor_bit;
                if ((cor_mask & cor_bit) == '0) begin
                    if (q.adv && unc_open) begin
                        v.log_req  = 1'b1;
                        v.log_bits = q.bits;
                        v.unc_set  = q.bits;
                    end
                    if ((!q.ur || en_ur) && en_cor) begin
                        v.msg = 1'b1;
                        v.sev = SEV_COR;
                    end
                end
            end else begin
                v.fatal_det    = q.fatal;
                v.nonfatal_det = !q.fatal;
                v.ur_det       = q.ur;
                v.unc_set      = q.bits;
                if (unc_open) begin
                    v.log_req  = 1'b1;
                    v.log_bits = q.bits;
                    if (!(q.ur && !en_ur && !serr) && class_en) begin
                        v.msg = 1'b1;
                        v.sev = q.fatal ? SEV_FATAL : SEV_NONFATAL;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/errsig_unit.sv
module errsig_unit
    import errsig_pkg::*;
#(
    parameter errvec_t     COR_SUPPORTED = 32'h0000_F1C1,
    parameter errvec_t     UNC_SUPPORTED = 32'h03FF_F030,
    parameter int unsigned UR_BIT        = 20,
    parameter int unsigned ADV_BIT       = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [ERR_W-1:0] req_status,
    input  logic             req_correctable,
    input  logic             req_advisory,
    input  logic [ERR_W-1:0] unc_mask,
    input  logic [ERR_W-1:0] unc_severity,
    input  logic [ERR_W-1:0] cor_mask,
    input  logic             en_cor_report,
    input  logic             en_nonfatal_report,
    input  logic             en_fatal_report,
    input  logic             en_ur_report,
    input  logic             sys_err_en,
    output logic             req_reject,
    output logic             sta_cor_det,
    output logic             sta_nonfatal_det,
    output logic             sta_fatal_det,
    output logic             sta_ur_det,
    output logic [ERR_W-1:0] cor_status_set,
    output logic [ERR_W-1:0] unc_status_set,
    output logic             log_valid,
    output logic [ERR_W-1:0] log_status,
    output logic             msg_valid,
    output logic [1:0]       msg_severity
);
    qual_t    qual;
    verdict_t next_v;
    verdict_t out_q;

    err_qualify #(
        .COR_SUPPORTED(COR_SUPPORTED),
        .UNC_SUPPORTED(UNC_SUPPORTED),
        .UR_BIT       (UR_BIT)
    ) u_qualify (
        .valid      (req_valid),
        .status     (req_status),
        .correctable(req_correctable),
        .advisory   (req_advisory),
        .severity   (unc_severity),
        .q          (qual)
    );

    err_decide #(
        .ADV_BIT(ADV_BIT)
    ) u_decide (
        .q          (qual),
        .unc_mask   (unc_mask),
        .cor_mask   (cor_mask),
        .en_cor     (en_cor_report),
        .en_nonfatal(en_nonfatal_report),
        .en_fatal   (en_fatal_report),
        .en_ur      (en_ur_report),
        .serr       (sys_err_en),
        .v          (next_v)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= next_v;
    end

    assign req_reject       = out_q.reject;
    assign sta_cor_det      = out_q.cor_det;
    assign sta_nonfatal_det = out_q.nonfatal_det;
    assign sta_fatal_det    = out_q.fatal_det;
    assign sta_ur_det       = out_q.ur_det;
    assign cor_status_set   = out_q.cor_set;
    assign unc_status_set   = out_q.unc_set;
    assign log_valid        = out_q.log_req;
    assign log_status       = out_q.log_bits;
    assign msg_valid        = out_q.msg;
    assign msg_severity     = out_q.sev;
endmodule

// File: rtl/errsig_checker.sv
module errsig_checker
    import errsig_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_reject,
    input logic             sta_cor_det,
    input logic             sta_nonfatal_det,
    input logic             sta_fatal_det,
    input logic [ERR_W-1:0] cor_status_set,
    input logic [ERR_W-1:0] unc_status_set,
    input logic             log_valid,
    input logic [ERR_W-1:0] log_status,
    input logic             msg_valid,
    input logic [1:0]       msg_severity
);
    assert_reject_alone_R2: assert property (@(posedge clk) disable iff (rst)
        req_reject |-> (!msg_valid && !log_valid && cor_status_set == '0 && unc_status_set == '0));

    assert_single_bit_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cor_status_set) && $onehot0(unc_status_set));

    assert_log_sets_status_R7: assert property (@(posedge clk) disable iff (rst)
        log_valid |-> ($countones(log_status) == 1 && unc_status_set == log_status));

    assert_cor_msg_detect_R4: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_severity == 2'b01) |-> sta_cor_det);

    assert_fatal_msg_detect_R8: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_severity == 2'b11) |-> sta_fatal_det);

    assert_class_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(sta_fatal_det && sta_nonfatal_det));

    assert_msg_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> ($past(req_valid) && msg_severity != 2'b00));
endmodule

bind errsig_unit errsig_checker u_errsig_checker (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_reject      (req_reject),
    .sta_cor_det     (sta_cor_det),
    .sta_nonfatal_det(sta_nonfatal_det),
    .sta_fatal_det   (sta_fatal_det),
    .cor_status_set  (cor_status_set),
    .unc_status_set  (unc_status_set),
    .log_valid       (log_valid),
    .log_status      (log_status),
    .msg_valid       (msg_valid),
    .msg_severity    (msg_severity)
);

// File: tb/errsig_unit_test.sv
module errsig_unit_test;
    localparam logic [31:0] COR_S  = 32'h0000_F1C1;
    localparam logic [31:0] UNC_S  = 32'h03FF_F030;
    localparam logic [31:0] UR_ONE  = 32'h0010_0000;
    localparam logic [31:0] ADV_ONE = 32'h0000_2000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_correctable = 1'b0, req_advisory = 1'b0;
    logic [31:0] req_status = '0;
    logic [31:0] um = '0, sev_r = '0, cm = '0;
    logic e_cor = 1'b1, e_nf = 1'b1, e_fa = 1'b1, e_ur = 1'b1, serr = 1'b0;
    logic req_reject, sta_cor_det, sta_nonfatal_det, sta_fatal_det, sta_ur_det;
    logic [31:0] cor_status_set, unc_status_set, log_status;
    logic log_valid, msg_valid;
    logic [1:0] msg_severity;

    int checks = 0;
    int errors = 0;
    logic [104:0] exp_q[$];
    string        tag_q[$];

    always #2 clk = ~clk;

    errsig_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_status(req_status),
        .req_correctable(req_correctable), .req_advisory(req_advisory),
        .unc_mask(um), .unc_severity(sev_r), .cor_mask(cm),
        .en_cor_report(e_cor), .en_nonfatal_report(e_nf), .en_fatal_report(e_fa),
        .en_ur_report(e_ur), .sys_err_en(serr),
        .req_reject(req_reject), .sta_cor_det(sta_cor_det),
        .sta_nonfatal_det(sta_nonfatal_det), .sta_fatal_det(sta_fatal_det),
        .sta_ur_det(sta_ur_det), .cor_status_set(cor_status_set),
        .unc_status_set(unc_status_set), .log_valid(log_valid),
        .log_status(log_status), .msg_valid(msg_valid), .msg_severity(msg_severity)
    );

    function automatic logic [104:0] observed();
        return {req_reject, sta_cor_det, sta_nonfatal_det, sta_fatal_det, sta_ur_det,
                cor_status_set, unc_status_set, log_valid, log_status,
                msg_valid, msg_severity};
    endfunction

    // Expected outcome derived from the requirement list
    function automatic logic [104:0] model(input logic v, input logic [31:0] st,
                                           input logic c, input logic a);
        logic rej = 0, ced = 0, nf = 0, fa = 0, urd = 0, lg = 0, mg = 0;
        logic [31:0] cs = '0, us = '0, ls = '0, b;
        logic [1:0] sv = 2'b00;
        logic ur, fat;
        if (v) begin
            b = st & (c ? COR_S : UNC_S);
            if ($countones(b) != 1) rej = 1;                       // R2
            else begin
                ur  = !c && (b == UR_ONE);
                fat = !c && ((b & sev_r) != 0);                     // R5
                if (c || (a && !fat)) begin                         // R3 R10
                    ced = 1; urd = ur; cs = c ? b : ADV_ONE;
                    if ((cm & cs) == 0) begin
                        if (!c && (um & b) == 0) begin lg = 1; ls = b; us = b; end
                        if ((!ur || e_ur) && e_cor) begin mg = 1; sv = 2'b01; end  // R4 R9
                    end
                end else begin
                    fa = fat; nf = !fat; urd = ur; us = b;          // R5 R6
                    if ((um & b) == 0) begin
                        lg = 1; ls = b;                              // R7
                        if (!(ur && !e_ur && !serr) && (serr || (fat ? e_fa : e_nf))) begin
                            mg = 1; sv = fat ? 2'b11 : 2'b10;        // R8 R9
                        end
                    end
                end
            end
        end
        return {rej, ced, nf, fa, urd, cs, us, lg, ls, mg, sv};
    endfunction

    task automatic send(input logic [31:0] st, input logic c, input logic a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_status = st; req_correctable = c; req_advisory = a;
        exp_q.push_back(model(1'b1, st, c, a));
        tag_q.push_back(tag);
        @(posedge clk); #1;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0; req_status = '0; req_correctable = 1'b0; req_advisory = 1'b0;
        exp_q.push_back(model(1'b0, '0, 1'b0, 1'b0));
        tag_q.push_back(tag);
        @(posedge clk); #1;
    endtask

    // Monitor: compares one expected item per cycle
    initial begin
        forever begin
            @(posedge clk); #1;
            if (exp_q.size() > 0) begin
                logic [104:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (observed() !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", t, observed(), e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=complete");
        finish_run();
    end

    initial begin
        sev_r = 32'h0000_0010;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        checks++;
        if (observed() !== '0) begin
            errors++;
            $display("FAIL R1 reset: actual=%h expected=0", observed());
        end
        send(32'h40, 1, 0, "R3 R4 R11 correctable reported");
        send(32'h3, 1, 0, "R2 unsupported bit filtered");
        send(32'h41, 1, 0, "R2 two bits rejected");
        send(32'h0, 1, 0, "R2 zero rejected");
        send(32'h1, 0, 0, "R2 bit unsupported in uncorrectable class");
        idle("R1 idle after requests");
        cm = 32'h40;  send(32'h40, 1, 0, "R3 masked correctable");  cm = '0;
        e_cor = 0;    send(32'h80, 1, 0, "R4 correctable enable off"); e_cor = 1;
        send(32'h10, 0, 0, "R5 R7 R8 fatal reported");
        e_fa = 0;     send(32'h10, 0, 0, "R8 fatal enable off");
        serr = 1;     send(32'h10, 0, 0, "R8 system error enable releases fatal");
        serr = 0;     e_fa = 1;
        send(32'h4000, 0, 0, "R5 R8 non-fatal reported");
        e_nf = 0;     send(32'h4000, 0, 0, "R8 non-fatal enable off"); e_nf = 1;
        um = 32'h4000; send(32'h4000, 0, 0, "R6 masked uncorrectable"); um = '0;
        send(UR_ONE, 0, 0, "R5 unsupported request detected");
        e_ur = 0;     send(UR_ONE, 0, 0, "R9 unsupported request suppressed");
        serr = 1;     send(UR_ONE, 0, 0, "R9 system error enable releases it");
        serr = 0;
        send(UR_ONE, 0, 1, "R9 R10 advisory unsupported request suppressed");
        serr = 1;     send(UR_ONE, 0, 1, "R9 R10 advisory not released by system error");
        serr = 0;     e_ur = 1;
        send(32'h4000, 0, 1, "R10 advisory non-fatal");
        um = 32'h4000; send(32'h4000, 0, 1, "R10 advisory with uncorrectable mask"); um = '0;
        cm = ADV_ONE; send(32'h4000, 0, 1, "R10 advisory with correctable mask"); cm = '0;
        e_cor = 0;    send(32'h4000, 0, 1, "R10 advisory needs correctable enable"); e_cor = 1;
        send(32'h10, 0, 1, "R10 fatal ignores advisory flag");
        send(32'h1000, 1, 0, "R11 back-to-back first");
        send(32'h1000, 0, 0, "R11 back-to-back second");
        send(32'h8000, 1, 0, "R11 back-to-back third");
        idle("R1 R11 pulse ends");
        idle("R1 quiet");
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule